// File: doc/BRIEF.md
# PCI Window DMA Address Translator

This block turns an address seen on the PCI bus into a system DMA address. It has four programmable windows. Each window has a base, a mask and a translated base, and all three are set through a simple indexed register port. A hit in an enabled window maps the address in one of two ways. Direct mode substitutes the upper bits from the translated base. Scatter-gather mode fetches one 64-bit page-table entry from memory and builds the address from that entry. An address that hits no enabled window leaves the block unchanged.

Translation requests arrive on a valid/ready handshake, and results leave on another. For scatter-gather, the block issues a one-cycle read request on its memory port. It then waits any number of cycles for the data-valid response. It takes no new request until the current result has been accepted. A writable control register is also present; it resets to a fixed non-zero pattern.

Top module: `pci_win_xlate`

## Requirements
- R1: After reset, every window base, mask and translated base reads as zero, and the control register reads 0x0000_0021_0010_0000 (bits 20 and 32 set, value 2 in bits 39:36).
- R2: Register index 0..3 selects the bases of windows 0..3, 4..7 the masks, 8..11 the translated bases and 12 the control register. All 64 bits of each are writable and read back on reg_rdata_o in the same cycle. Indices 13..15 read zero, and writes to them change nothing.
- R3: A window hits when the request address and the window base agree on every bit of 31:20 where the window mask is zero. Bits the mask sets in 31:20, and all bits outside 31:20, are not compared.
- R4: A window takes part only when bit 0 of its base is 1. Among enabled hitting windows, the lowest-numbered one is used.
- R5: When base bit 1 is 0 (direct mode), let K be the mask's bits 31:20 ORed with 0xFFFFF. The result is the request address inside K joined with the translated base outside K.
- R6: When base bit 1 is 1 (scatter-gather), let F be the mask's bits 31:20. The block issues exactly one one-cycle mem_req_o with mem_addr_o = (tbase AND NOT((F>>10) OR 0x3FF)) OR ((addr AND (F OR 0xFE000))>>10).
- R7: In scatter-gather mode the result is ((entry with bit 0 cleared) << 12) OR addr[12:0], where entry is the mem_rdata_i value delivered with mem_rvalid_i.
- R8: Every result produced by a window hit has bits 63:34 equal to zero.
- R9: When no enabled window hits, res_addr_o equals req_addr_i exactly, all 64 bits.
- R10: req_ready_o is high only while no translation is in progress. After a request is accepted it stays low until the result is taken. res_valid_o and res_addr_o hold until res_ready_i is high.
- R11: A register write in the same cycle as a request is accepted does not affect that translation; it uses the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index for read and write |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data of the indexed register |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 64 | PCI bus address to translate |
| res_valid_o | output | 1 | Translated address valid |
| res_ready_i | input | 1 | Consumer takes the result |
| res_addr_o | output | 64 | Translated (or passed-through) address |
| mem_req_o | output | 1 | One-cycle page-table read request |
| mem_addr_o | output | 64 | Page-table entry address |
| mem_rvalid_i | input | 1 | Page-table read data valid |
| mem_rdata_i | input | 64 | Page-table entry |

## Verification
A register write and the acceptance of a translation request can fall in the same clock edge. Both also compete for the window state, because a scatter-gather fetch can still be outstanding while the registers are rewritten. The bench provokes the first case on purpose: in the very cycle the request is accepted, it disables the window that would hit. It then expects the old mapping, and it expects pass-through on the next request. Random register writes are also mixed with translations whose memory latency and result stalls vary. A behavioural model applies writes only after deciding the translation in that cycle, and it judges every output on every cycle.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  localparam int DATA_W  = 64;
  localparam int OUT_W   = 34;
  localparam int EN_BIT  = 0;
  localparam int SG_BIT  = 1;
  localparam int FLD_LO  = 20;
  localparam int FLD_HI  = 31;
  localparam int PG_SH   = 13;
  localparam int PTE_SH  = 10;
  localparam int ENT_SH  = 12;
  localparam logic [DATA_W-1:0] CTRL_RST = 64'h0000_0021_0010_0000;

  typedef struct packed {
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] tbase;
  } pwx_win_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } pwx_st_e;
endpackage

// File: rtl/pwx_regs.sv
module pwx_regs
  import pwx_pkg::*;
#(
  parameter int WIN_N = 4,
  parameter int IDX_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output pwx_win_t [WIN_N-1:0]      win_o
);
  localparam int CTRL_IDX = 3 * WIN_N;

  logic [DATA_W-1:0] ctrl_q;

  for (genvar w = 0; w < WIN_N; w++) begin : g_win
    pwx_win_t win_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_q <= '0;
      end else if (we_i) begin
        if (idx_i == IDX_W'(w))           win_q.base  <= wdata_i;
        if (idx_i == IDX_W'(WIN_N + w))   win_q.mask  <= wdata_i;
        if (idx_i == IDX_W'(2*WIN_N + w)) win_q.tbase <= wdata_i;
      end
    end
    assign win_o[w] = win_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ctrl_q <= CTRL_RST;
    else if (we_i && idx_i == IDX_W'(CTRL_IDX))    ctrl_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < WIN_N; w++) begin
      if (idx_i == IDX_W'(w))           rdata_o = win_o[w].base;
      if (idx_i == IDX_W'(WIN_N + w))   rdata_o = win_o[w].mask;
      if (idx_i == IDX_W'(2*WIN_N + w)) rdata_o = win_o[w].tbase;
    end
    if (idx_i == IDX_W'(CTRL_IDX)) rdata_o = ctrl_q;
  end
endmodule

// File: rtl/pwx_match.sv
module pwx_match
  import pwx_pkg::*;
#(
  parameter int WIN_N = 4
) (
  input  logic [DATA_W-1:0]         bus_i,
  input  pwx_win_t [WIN_N-1:0]      win_i,
  output logic                      hit_o,
  output logic                      sg_o,
  output logic [DATA_W-1:0]         dir_o,
  output logic [DATA_W-1:0]         pte_o
);
  localparam int SEL_W = (WIN_N > 1) ? $clog2(WIN_N) : 1;
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);
  localparam logic [DATA_W-1:0] FLD_M  = (ONE << (FLD_HI + 1)) - (ONE << FLD_LO);
  localparam logic [DATA_W-1:0] LOW_M  = (ONE << FLD_LO) - ONE;
  localparam logic [DATA_W-1:0] IDX_M  = (ONE << FLD_LO) - (ONE << PG_SH);
  localparam logic [DATA_W-1:0] TBL_M  = (ONE << PTE_SH) - ONE;
  localparam logic [DATA_W-1:0] OUT_M  = (ONE << OUT_W) - ONE;

  logic [WIN_N-1:0] hit_vec;

  for (genvar w = 0; w < WIN_N; w++) begin : g_cmp
    logic [DATA_W-1:0] cmp_m;
    assign cmp_m      = ~win_i[w].mask & FLD_M;
    assign hit_vec[w] = win_i[w].base[EN_BIT] &&
                        ((bus_i & cmp_m) == (win_i[w].base & cmp_m));
  end

  logic [SEL_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int w = WIN_N - 1; w >= 0; w--) begin
      if (hit_vec[w]) sel = SEL_W'(w);
    end
  end

  pwx_win_t          win_s;
  logic [DATA_W-1:0] fld, dir_k, tb_k, bus_k;

  assign win_s = win_i[sel];
  assign fld   = win_s.mask & FLD_M;
  assign dir_k = fld | LOW_M;
  assign tb_k  = ~((fld >> PTE_SH) | TBL_M);
  assign bus_k = fld | IDX_M;

  assign hit_o = |hit_vec;
  assign sg_o  = win_s.base[SG_BIT];
  assign dir_o = ((win_s.tbase & ~dir_k) | (bus_i & dir_k)) & OUT_M;
  assign pte_o = (win_s.tbase & tb_k) | ((bus_i & bus_k) >> PTE_SH);
endmodule

// File: rtl/pwx_ctrl.sv
module pwx_ctrl
  import pwx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DATA_W-1:0] req_addr_i,
  input  logic              hit_i,
  input  logic              sg_i,
  input  logic [DATA_W-1:0] dir_i,
  input  logic [DATA_W-1:0] pte_i,
  output logic              mem_req_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_addr_o,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] OUT_M = (DATA_W'(1) << OUT_W) - DATA_W'(1);

  pwx_st_e           st_q;
  logic [DATA_W-1:0] res_q, pte_q;
  logic [PG_SH-1:0]  low_q;
  logic              hit_q;
  logic [DATA_W-1:0] ent_clr;

  assign ent_clr = {mem_rdata_i[DATA_W-1:1], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      res_q <= '0;
      pte_q <= '0;
      low_q <= '0;
      hit_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          hit_q <= hit_i;
          if (hit_i && sg_i) begin
            pte_q <= pte_i;
            low_q <= req_addr_i[PG_SH-1:0];
            st_q  <= ST_ISSUE;
          end else begin
            res_q <= hit_i ? dir_i : req_addr_i;
            st_q  <= ST_RESP;
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          res_q <= ((ent_clr << ENT_SH) | DATA_W'(low_q)) & OUT_M;
          st_q  <= ST_RESP;
        end
        ST_RESP: if (res_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_ISSUE);
  assign mem_addr_o  = pte_q;
  assign res_valid_o = (st_q == ST_RESP);
  assign res_addr_o  = res_q;
  assign hit_o       = hit_q;
endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate
  import pwx_pkg::*;
#(
  parameter  int WIN_N = 4,
  localparam int IDX_W = $clog2(3 * WIN_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_addr_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [63:0]       res_addr_o,
  output logic              mem_req_o,
  output logic [63:0]       mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i
);
  pwx_win_t [WIN_N-1:0] win;
  logic                 m_hit, m_sg, xl_hit;
  logic [DATA_W-1:0]    m_dir, m_pte;

  pwx_regs #(.WIN_N(WIN_N), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .win_o   (win)
  );

  pwx_match #(.WIN_N(WIN_N)) u_match (
    .bus_i (req_addr_i),
    .win_i (win),
    .hit_o (m_hit),
    .sg_o  (m_sg),
    .dir_o (m_dir),
    .pte_o (m_pte)
  );

  pwx_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_addr_i   (req_addr_i),
    .hit_i        (m_hit),
    .sg_i         (m_sg),
    .dir_i        (m_dir),
    .pte_i        (m_pte),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .res_valid_o  (res_valid_o),
    .res_ready_i  (res_ready_i),
    .res_addr_o   (res_addr_o),
    .hit_o        (xl_hit)
  );
endmodule

// File: rtl/pwx_chk.sv
module pwx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        res_valid_o,
  input logic        res_ready_i,
  input logic [63:0] res_addr_o,
  input logic        mem_req_o,
  input logic        xl_hit
);
  // R10
  ready_resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && res_valid_o));

  // R10
  accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R10
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_addr_o)));

  // R6
  mem_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R6
  mem_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  // R8
  hit_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && xl_hit) |-> (res_addr_o[63:34] == '0));
endmodule

bind pci_win_xlate pwx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_addr_o  (res_addr_o),
  .mem_req_o   (mem_req_o),
  .xl_hit      (xl_hit)
);

// File: tb/tb_pci_win_xlate.sv
`timescale 1ns/1ps
module tb_pci_win_xlate;
  localparam logic [63:0] CTRL0 = 64'h0000_0021_0010_0000;
  localparam logic [63:0] OUTM  = 64'h0000_0003_FFFF_FFFF;
  localparam logic [63:0] FLDM  = 64'h0000_0000_FFF0_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_idx_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_addr_i = '0;
  logic        res_valid_o;
  logic        res_ready_i = 1'b0;
  logic [63:0] res_addr_o;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  always #4 clk = ~clk;

  pci_win_xlate dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_addr_o(res_addr_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  int checks = 0;
  int fails  = 0;
  int mreq_cnt = 0;
  int lat_sel = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] ent(input logic [63:0] a);
    return {a[31:0], a[63:32]} ^ 64'h0A5C_3300_00F0_1E01;
  endfunction

  // behavioural reference state
  logic [63:0] mb[4], mm[4], mt[4], mc;
  int          ph;
  logic [63:0] m_res, m_pte;
  logic [12:0] m_low;
  bit          m_hit, m_sg;

  function automatic void ref_x(input logic [63:0] b, output bit hit, output bit sg,
                                output logic [63:0] res, output logic [63:0] pte);
    logic [63:0] cm, fm, k;
    hit = 0; sg = 0; res = b; pte = '0;
    for (int w = 0; w < 4; w++) begin
      cm = ~mm[w] & FLDM;
      if (!hit && mb[w][0] && ((b & cm) == (mb[w] & cm))) begin
        hit = 1;
        sg  = mb[w][1];
        fm  = mm[w] & FLDM;
        if (sg) begin
          pte = (mt[w] & ~((fm >> 10) | 64'h3FF)) | ((b & (fm | 64'hFE000)) >> 10);
        end else begin
          k   = fm | 64'hFFFFF;
          res = ((mt[w] & ~k) | (b & k)) & OUTM;
        end
      end
    end
  endfunction

  function automatic logic [63:0] ref_rd(input logic [3:0] i);
    if (i < 4)       return mb[i];
    else if (i < 8)  return mm[i-4];
    else if (i < 12) return mt[i-8];
    else if (i == 12) return mc;
    return '0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    bit h, s;
    logic [63:0] r, p;
    if (!rst_ni) begin
      ph = 0;
      for (int w = 0; w < 4; w++) begin mb[w] = '0; mm[w] = '0; mt[w] = '0; end
      mc = CTRL0; m_res = '0; m_pte = '0; m_low = '0; m_hit = 0; m_sg = 0;
    end else begin
      case (ph)
        0: if (req_valid_i) begin
          ref_x(req_addr_i, h, s, r, p);
          m_hit = h; m_sg = h && s;
          if (h && s) begin m_pte = p; m_low = req_addr_i[12:0]; ph = 1; end
          else begin m_res = r; ph = 3; end
        end
        1: ph = 2;
        2: if (mem_rvalid_i) begin
          m_res = (({mem_rdata_i[63:1], 1'b0} << 12) | {51'd0, m_low}) & OUTM;
          ph = 3;
        end
        default: if (res_ready_i) ph = 0;
      endcase
      if (reg_we_i) begin
        if (reg_idx_i < 4)        mb[reg_idx_i]   = reg_wdata_i;
        else if (reg_idx_i < 8)   mm[reg_idx_i-4] = reg_wdata_i;
        else if (reg_idx_i < 12)  mt[reg_idx_i-8] = reg_wdata_i;
        else if (reg_idx_i == 12) mc = reg_wdata_i;
      end
    end
  end

  // per-cycle compare and memory responder, away from the active edge
  bit          pend = 0;
  int          cnt = 0;
  logic [63:0] paddr = '0;
  logic [63:0] last_maddr = '0;
  always begin
    @(negedge clk); #1;
    if (rst_ni && !done) begin
      chk("R2 reg_rdata", reg_rdata_o, ref_rd(reg_idx_i));
      chk("R10 req_ready", {63'd0, req_ready_o}, {63'd0, ph == 0});
      chk("R6 mem_req", {63'd0, mem_req_o}, {63'd0, ph == 1});
      if (ph == 1) chk("R6 mem_addr", mem_addr_o, m_pte);
      chk("R10 res_valid", {63'd0, res_valid_o}, {63'd0, ph == 3});
      if (ph == 3) chk(m_sg ? "R7 res_addr" : (m_hit ? "R5 res_addr" : "R9 res_addr"),
                       res_addr_o, m_res);
    end
    mem_rvalid_i = 1'b0;
    if (pend) begin
      if (cnt == 0) begin mem_rvalid_i = 1'b1; mem_rdata_i = ent(paddr); pend = 0; end
      else cnt--;
    end
    if (rst_ni && mem_req_o) begin
      pend = 1; paddr = mem_addr_o; last_maddr = mem_addr_o; mreq_cnt++;
      cnt = lat_sel % 5; lat_sel++;
    end
  end

  task automatic wr(input logic [3:0] i, input logic [63:0] d);
    @(negedge clk); reg_we_i = 1'b1; reg_idx_i = i; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, input logic [63:0] exp, input string tag);
    @(negedge clk); reg_idx_i = i; #2;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic xl(input logic [63:0] a, input int stall, input bit dow,
                    input logic [3:0] wi, input logic [63:0] wd, output logic [63:0] r);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a;
    if (dow) begin reg_we_i = 1'b1; reg_idx_i = wi; reg_wdata_i = wd; end
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0; reg_we_i = 1'b0;
    while (!res_valid_o) @(negedge clk);
    repeat (stall) @(negedge clk);
    r = res_addr_o;
    res_ready_i = 1'b1;
    @(negedge clk);
    res_ready_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] r;
    int m0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    for (int i = 0; i < 12; i++) rd(4'(i), 64'd0, "R1 window reg reset");
    rd(4'd12, CTRL0, "R1 ctrl reset");

    // R2 map, writability, unmapped index
    wr(4'd12, 64'hFFFF_0000_1234_ABCD);
    rd(4'd12, 64'hFFFF_0000_1234_ABCD, "R2 ctrl write");
    wr(4'd14, 64'hDEAD_BEEF_DEAD_BEEF);
    rd(4'd14, 64'd0, "R2 unmapped reads zero");
    for (int i = 0; i < 12; i++) rd(4'(i), 64'd0, "R2 unmapped write no effect");
    wr(4'd6, 64'hA5A5_A5A5_5A5A_5A5A);
    rd(4'd6, 64'hA5A5_A5A5_5A5A_5A5A, "R2 mask2 write");
    wr(4'd6, 64'd0);

    // R9 miss with nothing enabled
    xl(64'hDEAD_BEEF_1234_5678, 0, 0, 0, 0, r);
    chk("R9 pass-through", r, 64'hDEAD_BEEF_1234_5678);

    // R5 direct window 1
    wr(4'd1, 64'h4000_0001);
    wr(4'd5, 64'h0FF0_0000);
    wr(4'd9, 64'h3_8000_0000);
    xl(64'h4123_4567, 2, 0, 0, 0, r);
    chk("R5 direct map", r, 64'h3_8123_4567);
    // R3 compare region
    xl(64'h5123_4567, 0, 0, 0, 0, r);
    chk("R3 compare miss", r, 64'h5123_4567);
    xl(64'hFFFF_0000_4FFF_FFFF, 0, 0, 0, 0, r);
    chk("R3 high bits not compared", r, 64'h3_8FFF_FFFF);

    // R8 truncation
    wr(4'd9, 64'hFFFF_FFF0_0000_0000);
    xl(64'h4123_4567, 0, 0, 0, 0, r);
    chk("R8 34-bit limit", r, 64'h0123_4567);
    wr(4'd9, 64'h3_8000_0000);

    // R4 priority and enable
    wr(4'd0, 64'h4000_0001);
    wr(4'd4, 64'h0FF0_0000);
    wr(4'd8, 64'h1000_0000);
    xl(64'h4123_4567, 1, 0, 0, 0, r);
    chk("R4 lowest index wins", r, 64'h1123_4567);
    wr(4'd0, 64'h4000_0000);
    xl(64'h4123_4567, 0, 0, 0, 0, r);
    chk("R4 disabled skipped", r, 64'h3_8123_4567);

    // R6/R7 scatter-gather window 2
    wr(4'd2, 64'h8000_0003);
    wr(4'd6, 64'h0010_0000);
    wr(4'd10, 64'h1234_8000);
    m0 = mreq_cnt;
    xl(64'h8012_3456, 3, 0, 0, 0, r);
    chk("R6 entry address", last_maddr, 64'h1234_8488);
    chk("R6 single read", 64'(mreq_cnt - m0), 64'd1);
    chk("R7 sg result", r,
        ((({ent(64'h1234_8488)} & ~64'd1) << 12) | 64'h1456) & OUTM);

    // R11 write in the accepting cycle
    xl(64'h4123_4567, 0, 1, 4'd1, 64'd0, r);
    chk("R11 old regs used", r, 64'h3_8123_4567);
    xl(64'h4123_4567, 0, 0, 0, 0, r);
    chk("R11 write then applied", r, 64'h4123_4567);

    // random mix, judged by the per-cycle model
    for (int n = 0; n < 300; n++) begin
      logic [63:0] b, d;
      int w;
      w = $urandom_range(0, 3);
      case ($urandom_range(0, 4))
        0: wr(4'(w), {32'd0, $urandom} | 64'h1);
        1: wr(4'(4 + w), {32'd0, $urandom} & FLDM);
        2: wr(4'(8 + w), {$urandom, $urandom});
        3: wr(4'($urandom_range(12, 15)), {$urandom, $urandom});
        default: ;
      endcase
      d = ref_rd(4'($urandom_range(0, 3)));
      b = {$urandom, (d[31:20] ^ ($urandom_range(0, 3) == 0 ? 12'h001 : 12'h000)),
           20'($urandom)};
      xl(b, $urandom_range(0, 3), ($urandom_range(0, 7) == 0), 4'($urandom_range(0, 15)),
         {$urandom, $urandom}, r);
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule